// File: doc/BRIEF.md
# Calendar Clock with Time Alarm

This block is a real-time calendar core held in a byte-wide register file. It counts seconds, minutes, hours, weekday, day of month, month and two-digit year. It steps one second for each pulse on a once-per-second input. Three alarm registers hold the seconds, minutes and hours to match. Software reaches every register through a synchronous port. A write takes effect at the clock edge where the write strobe is sampled. Read data is registered and appears on the cycle after the read strobe.

A control byte selects the representation used on the bus at run time: packed BCD or plain binary, and a 12-hour clock with a PM marker or a 24-hour clock. The counters are kept internally in binary, so a change of representation takes effect at once on every register. The same control byte can freeze the clock while software loads a new time. It also masks the update and alarm events onto a single interrupt line. A status byte reports those events and clears itself when read. A busy indicator warns software that an increment is about to land.

Top module: `cal_clock`

## Requirements
- R1: After reset the time reads 00:00:00 with weekday 1, day 1, month 1 and year 0. All alarm registers, the control byte and the status byte are zero, and irq is low. In the reset format (12-hour, BCD) the hours and hours-alarm registers read 0x12.
- R2: Byte offsets: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday, 7 day of month, 8 month, 9 year, 10 busy register, 11 control byte, 12 status byte. Any other offset reads 0. Read data appears on the cycle after rd_en.
- R3: A tick_1hz pulse sampled while idle makes bit 7 of offset 10 read 1 for exactly UIP_CYCLES cycles. The time advances by one second at the end of that window. Ticks during the window are ignored. Writes to offset 10 have no effect.
- R4: While control bit 7 is set, ticks are ignored. Setting the bit during a busy window cancels the pending increment.
- R5: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the date.
- R6: The day of month wraps after the last day of the month: 30 days for months 4, 6, 9 and 11, and 31 for the other months except February. The month wraps from 12 to 1 and increments the year. The year wraps from YEAR_LIMIT to 0. The weekday wraps from 7 to 1.
- R7: When the year is divisible by 4, February has 29 days; otherwise it has 28.
- R8: Control bit 2 set selects binary values, and clear selects packed BCD (tens in bits 7:4, units in bits 3:0). The selection applies to reads and writes of all count and alarm registers.
- R9: Control bit 1 set selects 24-hour hours (0 to 23). Clear selects 12-hour hours, with bit 7 marking PM and the value running 12, 1, ..., 11. The clock moves from 11:59:59 AM to 12 PM and from 11:59:59 PM to 12 AM.
- R10: Every increment sets status bit 4.
- R11: Status bit 5 is set when the seconds, minutes and hours just produced by an increment all equal the alarm registers.
- R12: Status bit 7 and irq are high when status bit 4 is set with control bit 4, or status bit 5 is set with control bit 5. Status bit 6 always reads 0, so control bit 6 never raises irq.
- R13: Reading offset 12 returns the status byte as it stood, then clears bits 4 and 5. A flag set in the same cycle as the clear is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined masked interrupt |

## Verification
Checked on every cycle:
- The busy window starts only after a tick, and an increment lands only inside that window.
- A frozen clock with no write keeps its time.
- A single increment adds exactly one to the seconds below 59.
- December rolls to January.
- An increment always raises the update flag.
- A read of the status byte leaves the flags clear.
- irq is never high with no flag set.

Only the bench scenarios can show:
- The month lengths and the leap-year rule across the month and year sweep.
- The BCD and 12-hour encodings over every hour in every mode.
- The length of the busy window.
- The alarm match and the masking.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

   // register byte offsets
   localparam int unsigned OFS_SEC    = 0;
   localparam int unsigned OFS_SEC_AL = 1;
   localparam int unsigned OFS_MIN    = 2;
   localparam int unsigned OFS_MIN_AL = 3;
   localparam int unsigned OFS_HR     = 4;
   localparam int unsigned OFS_HR_AL  = 5;
   localparam int unsigned OFS_DOW    = 6;
   localparam int unsigned OFS_DOM    = 7;
   localparam int unsigned OFS_MON    = 8;
   localparam int unsigned OFS_YR     = 9;
   localparam int unsigned OFS_BUSY   = 10;
   localparam int unsigned OFS_CTL    = 11;
   localparam int unsigned OFS_STAT   = 12;
   localparam int unsigned NUM_OFS    = 13;

   // control byte bit positions
   localparam int unsigned CB_H24  = 1;
   localparam int unsigned CB_BIN  = 2;
   localparam int unsigned CB_UMSK = 4;
   localparam int unsigned CB_AMSK = 5;
   localparam int unsigned CB_FRZ  = 7;

   typedef struct packed {
      logic [5:0] sec;
      logic [5:0] min;
      logic [4:0] hr;
      logic [2:0] dow;
      logic [4:0] dom;
      logic [3:0] mon;
      logic [6:0] yr;
   } cal_time_t;

   localparam cal_time_t TIME_AT_RESET = '{sec: 6'd0, min: 6'd0, hr: 5'd0,
                                           dow: 3'd1, dom: 5'd1, mon: 4'd1,
                                           yr: 7'd0};

   function automatic logic [7:0] to_bcd(input logic [6:0] v);
      logic [6:0] tens, ones;
      tens = v / 7'd10;
      ones = v - tens * 7'd10;
      return {tens[3:0], ones[3:0]};
   endfunction

   function automatic logic [6:0] from_bcd(input logic [7:0] b);
      logic [6:0] hi, lo;
      hi = {3'b000, b[7:4]};
      lo = {3'b000, b[3:0]};
      return hi * 7'd10 + lo;
   endfunction

   function automatic logic [7:0] enc_num(input logic [6:0] v, input logic bin);
      return bin ? {1'b0, v} : to_bcd(v);
   endfunction

   function automatic logic [6:0] dec_num(input logic [7:0] b, input logic bin);
      return bin ? b[6:0] : from_bcd(b);
   endfunction

   // internal hour 0..23 to bus byte
   function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                           input logic h24);
      logic [6:0] hx;
      logic [7:0] e;
      logic       pm;
      if (h24) return enc_num({2'b00, h}, bin);
      pm = (h >= 5'd12);
      hx = {2'b00, h};
      if (pm) hx = hx - 7'd12;
      if (hx == 7'd0) hx = 7'd12;
      e = enc_num(hx, bin);
      return {pm, e[6:0]};
   endfunction

   // bus byte to internal hour 0..23
   function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin,
                                           input logic h24);
      logic [6:0] v;
      if (h24) begin
         v = dec_num(b, bin);
         return v[4:0];
      end
      v = dec_num({1'b0, b[6:0]}, bin);
      if (v == 7'd12) v = 7'd0;
      if (b[7]) v = v + 7'd12;
      return v[4:0];
   endfunction

   function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
      case (mon)
         4'd2:                      return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
         default:                   return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/cal_clock_step.sv
module cal_clock_step
   import cal_clock_pkg::*;
#(
   parameter int unsigned YEAR_LIMIT = 99
) (
   input  cal_time_t cur,
   output cal_time_t nxt
);

   localparam logic [6:0] YR_TOP = 7'(YEAR_LIMIT);

   logic c_min, c_hr, c_day, c_mon, c_yr;

   // ripple of carries from seconds up to the year
   always_comb begin
      nxt   = cur;
      c_min = (cur.sec >= 6'd59);
      nxt.sec = c_min ? 6'd0 : cur.sec + 6'd1;

      c_hr = c_min && (cur.min >= 6'd59);
      if (c_min) nxt.min = (cur.min >= 6'd59) ? 6'd0 : cur.min + 6'd1;

      c_day = c_hr && (cur.hr >= 5'd23);
      if (c_hr) nxt.hr = (cur.hr >= 5'd23) ? 5'd0 : cur.hr + 5'd1;

      c_mon = c_day && (cur.dom >= month_days(cur.mon, cur.yr));
      if (c_day) begin
         nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
         nxt.dom = c_mon ? 5'd1 : cur.dom + 5'd1;
      end

      c_yr = c_mon && (cur.mon >= 4'd12);
      if (c_mon) nxt.mon = c_yr ? 4'd1 : cur.mon + 4'd1;
      if (c_yr)  nxt.yr  = (cur.yr >= YR_TOP) ? 7'd0 : cur.yr + 7'd1;
   end

endmodule

// File: rtl/cal_clock_seq.sv
module cal_clock_seq #(
   parameter int unsigned UIP_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic freeze,
   output logic busy,
   output logic apply
);

   localparam int unsigned CW = $clog2(UIP_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (freeze)         cnt_q <= '0;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
      else if (tick)           cnt_q <= CW'(UIP_CYCLES);
   end

   assign busy  = (cnt_q != '0);
   assign apply = (cnt_q == CW'(1)) && !freeze;

endmodule

// File: rtl/cal_clock_alarm.sv
module cal_clock_alarm
   import cal_clock_pkg::*;
(
   input  cal_time_t  t,
   input  logic [5:0] al_sec,
   input  logic [5:0] al_min,
   input  logic [4:0] al_hr,
   output logic       hit
);

   localparam int unsigned NF = 3;

   logic [5:0]    lhs [NF];
   logic [5:0]    rhs [NF];
   logic [NF-1:0] eq;

   assign lhs[0] = t.sec;
   assign lhs[1] = t.min;
   assign lhs[2] = {1'b0, t.hr};
   assign rhs[0] = al_sec;
   assign rhs[1] = al_min;
   assign rhs[2] = {1'b0, al_hr};

   for (genvar g = 0; g < NF; g++) begin : g_cmp
      assign eq[g] = (lhs[g] == rhs[g]);
   end

   assign hit = &eq;

endmodule

// File: rtl/cal_clock.sv
module cal_clock
   import cal_clock_pkg::*;
#(
   parameter int unsigned UIP_CYCLES = 8,
   parameter int unsigned YEAR_LIMIT = 99,
   parameter int unsigned ADDR_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq
);

   initial begin : elab_checks
      assert (UIP_CYCLES >= 1) else $fatal(1, "UIP_CYCLES must be at least 1");
      assert (ADDR_W >= 4 && ADDR_W <= 8) else $fatal(1, "ADDR_W out of range");
      assert (YEAR_LIMIT >= 1 && YEAR_LIMIT <= 99) else $fatal(1, "YEAR_LIMIT out of range");
   end

   cal_time_t    now_q, now_d, stepped;
   logic [5:0]   al_sec_q, al_min_q;
   logic [4:0]   al_hr_q;
   logic [7:0]   ctl_q;
   logic         uf_q, af_q;
   logic [7:0]   rdata_q, rd_mux, stat_byte;
   logic         busy, apply, hit, rd_clr;
   logic         fmt_bin, fmt_h24;
   logic [6:0]   wdec;
   logic [4:0]   hdec;
   logic [NUM_OFS-1:0] sel, wsel;

   assign fmt_bin = ctl_q[CB_BIN];
   assign fmt_h24 = ctl_q[CB_H24];

   // one-hot offset decode
   for (genvar g = 0; g < NUM_OFS; g++) begin : g_dec
      assign sel[g]  = (addr == ADDR_W'(g));
      assign wsel[g] = sel[g] & wr_en;
   end

   assign rd_clr = rd_en & sel[OFS_STAT];

   cal_clock_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_1hz),
      .freeze (ctl_q[CB_FRZ]),
      .busy   (busy),
      .apply  (apply)
   );

   cal_clock_step #(.YEAR_LIMIT(YEAR_LIMIT)) u_step (
      .cur (now_q),
      .nxt (stepped)
   );

   cal_clock_alarm u_alarm (
      .t      (stepped),
      .al_sec (al_sec_q),
      .al_min (al_min_q),
      .al_hr  (al_hr_q),
      .hit    (hit)
   );

   assign wdec = dec_num(wdata, fmt_bin);
   assign hdec = dec_hour(wdata, fmt_bin, fmt_h24);

   // next time: the increment first, then any field software writes
   always_comb begin
      now_d = apply ? stepped : now_q;
      if (wsel[OFS_SEC]) now_d.sec = wdec[5:0];
      if (wsel[OFS_MIN]) now_d.min = wdec[5:0];
      if (wsel[OFS_HR])  now_d.hr  = hdec;
      if (wsel[OFS_DOW]) now_d.dow = wdec[2:0];
      if (wsel[OFS_DOM]) now_d.dom = wdec[4:0];
      if (wsel[OFS_MON]) now_d.mon = wdec[3:0];
      if (wsel[OFS_YR])  now_d.yr  = wdec;
   end

   assign irq       = (uf_q & ctl_q[CB_UMSK]) | (af_q & ctl_q[CB_AMSK]);
   assign stat_byte = {irq, 1'b0, af_q, uf_q, 4'b0000};

   always_comb begin
      rd_mux = 8'h00;
      if      (sel[OFS_SEC])    rd_mux = enc_num({1'b0, now_q.sec}, fmt_bin);
      else if (sel[OFS_SEC_AL]) rd_mux = enc_num({1'b0, al_sec_q}, fmt_bin);
      else if (sel[OFS_MIN])    rd_mux = enc_num({1'b0, now_q.min}, fmt_bin);
      else if (sel[OFS_MIN_AL]) rd_mux = enc_num({1'b0, al_min_q}, fmt_bin);
      else if (sel[OFS_HR])     rd_mux = enc_hour(now_q.hr, fmt_bin, fmt_h24);
      else if (sel[OFS_HR_AL])  rd_mux = enc_hour(al_hr_q, fmt_bin, fmt_h24);
      else if (sel[OFS_DOW])    rd_mux = enc_num({4'b0000, now_q.dow}, fmt_bin);
      else if (sel[OFS_DOM])    rd_mux = enc_num({2'b00, now_q.dom}, fmt_bin);
      else if (sel[OFS_MON])    rd_mux = enc_num({3'b000, now_q.mon}, fmt_bin);
      else if (sel[OFS_YR])     rd_mux = enc_num(now_q.yr, fmt_bin);
      else if (sel[OFS_BUSY])   rd_mux = {busy, 7'b0000000};
      else if (sel[OFS_CTL])    rd_mux = ctl_q;
      else if (sel[OFS_STAT])   rd_mux = stat_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_q    <= TIME_AT_RESET;
         al_sec_q <= '0;
         al_min_q <= '0;
         al_hr_q  <= '0;
         ctl_q    <= '0;
         uf_q     <= 1'b0;
         af_q     <= 1'b0;
         rdata_q  <= '0;
      end else begin
         now_q <= now_d;
         if (wsel[OFS_SEC_AL]) al_sec_q <= wdec[5:0];
         if (wsel[OFS_MIN_AL]) al_min_q <= wdec[5:0];
         if (wsel[OFS_HR_AL])  al_hr_q  <= hdec;
         if (wsel[OFS_CTL])    ctl_q    <= wdata;
         // a new event beats the clear-on-read
         uf_q <= (uf_q & ~rd_clr) | apply;
         af_q <= (af_q & ~rd_clr) | (apply & hit);
         if (rd_en) rdata_q <= rd_mux;
      end
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
   import cal_clock_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      tick,
   input logic      busy,
   input logic      apply,
   input logic      freeze,
   input logic      wr_en,
   input logic      rd_clr,
   input cal_time_t now,
   input logic      uf,
   input logic      af,
   input logic      irq
);

   assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tick));

   assert_apply_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      apply |-> busy);

   assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(freeze) && !$past(wr_en)) |-> (now == $past(now)));

   assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(apply) && !$past(wr_en) && ($past(now.sec) < 6'd59))
         |-> (now.sec == $past(now.sec) + 6'd1));

   assert_month_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(apply) && !$past(wr_en) && ($past(now.mon) == 4'd12) && (now.mon != 4'd12))
         |-> (now.mon == 4'd1));

   assert_update_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(apply) |-> uf);

   assert_no_irq_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!uf && !af) |-> !irq);

   assert_read_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_clr) && !$past(apply)) |-> (!uf && !af));

endmodule

bind cal_clock cal_clock_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick_1hz),
   .busy   (busy),
   .apply  (apply),
   .freeze (ctl_q[7]),
   .wr_en  (wr_en),
   .rd_clr (rd_clr),
   .now    (now_q),
   .uf     (uf_q),
   .af     (af_q),
   .irq    (irq)
);

// File: tb/test_cal_clock.sv
module test_cal_clock;

   localparam int NU = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;

   int   n_tot = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   cal_clock #(.UIP_CYCLES(NU), .YEAR_LIMIT(99), .ADDR_W(4)) i_cal_clock (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   function automatic logic [7:0] bcd8(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction

   function automatic logic [7:0] fmtv(input int v, input bit bin);
      return bin ? 8'(v) : bcd8(v);
   endfunction

   function automatic logic [7:0] fmt_hr(input int h, input bit bin, input bit h24);
      int h12;
      if (h24) return fmtv(h, bin);
      h12 = (h == 0) ? 12 : ((h > 12) ? h - 12 : h);
      return fmtv(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
   endfunction

   function automatic int mlen(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tot++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input int a, input logic [7:0] d);
      wr_en = 1'b1; addr = 4'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      rd_en = 1'b1; addr = 4'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic pulse();
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
   endtask

   task automatic tick_wait();
      pulse();
      repeat (NU + 1) @(negedge clk);
   endtask

   // loads a binary 24-hour time and leaves the clock frozen
   task automatic set_time(input int h, input int mi, input int s, input int dw,
                           input int dm, input int mo, input int yr);
      wr(11, 8'h86);
      wr(0, 8'(s)); wr(2, 8'(mi)); wr(4, 8'(h));
      wr(6, 8'(dw)); wr(7, 8'(dm)); wr(8, 8'(mo)); wr(9, 8'(yr));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tot++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
         $finish;
      end
   end

   initial begin : main
      int yl[6];
      yl = '{0, 1, 2, 3, 98, 99};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2: reset contents in 12-hour BCD
      rd(0, rv);  chk("R1 sec", rv, 8'h00);
      rd(1, rv);  chk("R1 sec alarm", rv, 8'h00);
      rd(2, rv);  chk("R1 min", rv, 8'h00);
      rd(3, rv);  chk("R1 min alarm", rv, 8'h00);
      rd(4, rv);  chk("R1 hour 12AM", rv, 8'h12);
      rd(5, rv);  chk("R1 hour alarm", rv, 8'h12);
      rd(6, rv);  chk("R1 weekday", rv, 8'h01);
      rd(7, rv);  chk("R1 day", rv, 8'h01);
      rd(8, rv);  chk("R1 month", rv, 8'h01);
      rd(9, rv);  chk("R1 year", rv, 8'h00);
      rd(11, rv); chk("R1 control", rv, 8'h00);
      rd(12, rv); chk("R1 status", rv, 8'h00);
      chk("R1 irq", 8'(irq), 8'h00);
      rd(13, rv); chk("R2 unmapped", rv, 8'h00);

      // R3: busy window length and the increment after it
      set_time(1, 2, 3, 1, 1, 1, 0);
      wr(11, 8'h06);
      pulse();
      for (int k = 0; k < NU; k++) begin
         rd(10, rv); chk("R3 busy high", rv, 8'h80);
      end
      rd(10, rv); chk("R3 busy low", rv, 8'h00);
      rd(0, rv);  chk("R3 sec advanced", rv, 8'd4);
      // R3: second tick inside the window ignored
      pulse(); pulse();
      repeat (NU + 4) @(negedge clk);
      rd(0, rv);  chk("R3 one step only", rv, 8'd5);
      wr(10, 8'hFF);
      rd(10, rv); chk("R3 busy write ignored", rv, 8'h00);

      // R4: freeze blocks ticks and cancels a pending increment
      wr(11, 8'h86);
      pulse();
      rd(10, rv); chk("R4 no busy while frozen", rv, 8'h00);
      repeat (NU + 1) @(negedge clk);
      rd(0, rv);  chk("R4 frozen sec", rv, 8'd5);
      wr(11, 8'h06);
      pulse();
      wr(11, 8'h86);
      repeat (NU + 1) @(negedge clk);
      rd(0, rv);  chk("R4 cancelled sec", rv, 8'd5);

      // R5: minute and hour carry
      set_time(10, 59, 59, 3, 5, 5, 1);
      wr(11, 8'h06);
      tick_wait();
      rd(0, rv); chk("R5 sec wrap", rv, 8'd0);
      rd(2, rv); chk("R5 min wrap", rv, 8'd0);
      rd(4, rv); chk("R5 hour carry", rv, 8'd11);
      rd(7, rv); chk("R5 day kept", rv, 8'd5);

      // R6 / R7: last second of every month over several years
      for (int yi = 0; yi < 6; yi++) begin
         for (int m = 1; m <= 12; m++) begin
            int y, dm, dw, ndw, nm, ny;
            y   = yl[yi];
            dm  = mlen(m, y);
            dw  = (m % 7) + 1;
            ndw = (dw == 7) ? 1 : dw + 1;
            nm  = (m == 12) ? 1 : m + 1;
            ny  = (m == 12) ? ((y == 99) ? 0 : y + 1) : y;
            set_time(23, 59, 59, dw, dm, m, y);
            wr(11, 8'h06);
            tick_wait();
            rd(4, rv); chk("R5 hour wrap", rv, 8'd0);
            rd(6, rv); chk("R6 weekday", rv, 8'(ndw));
            rd(7, rv); chk("R6 day wrap", rv, 8'd1);
            rd(8, rv); chk("R6 month", rv, 8'(nm));
            rd(9, rv); chk("R6 year", rv, 8'(ny));
         end
      end
      set_time(23, 59, 59, 2, 28, 2, 4);
      wr(11, 8'h06);
      tick_wait();
      rd(7, rv); chk("R7 leap Feb 29", rv, 8'd29);
      rd(8, rv); chk("R7 leap still Feb", rv, 8'd2);

      // R8 / R9: encodings of every hour in every mode, both directions
      for (int md = 0; md < 4; md++) begin
         for (int h = 0; h < 24; h++) begin
            bit bin, h24;
            logic [7:0] mode, e;
            bin  = md[0];
            h24  = md[1];
            mode = 8'h80 | (bin ? 8'h04 : 8'h00) | (h24 ? 8'h02 : 8'h00);
            e    = fmt_hr(h, bin, h24);
            wr(11, 8'h86); wr(4, 8'(h)); wr(11, mode);
            rd(4, rv); chk(h24 ? "R9 hour read 24h" : "R9 hour read 12h", rv, e);
            wr(4, e); wr(11, 8'h86);
            rd(4, rv); chk(bin ? "R8 hour write binary" : "R8 hour write BCD", rv, 8'(h));
         end
      end
      for (int v = 0; v < 60; v++) begin
         wr(11, 8'h86); wr(2, 8'(v)); wr(11, 8'h80);
         rd(2, rv); chk("R8 minute BCD", rv, bcd8(v));
      end

      // R8 / R9: counting in BCD 12-hour
      wr(11, 8'h80); wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h91);
      wr(11, 8'h00);
      tick_wait();
      rd(4, rv); chk("R9 11PM to 12AM", rv, 8'h12);
      rd(2, rv); chk("R8 BCD min wrap", rv, 8'h00);
      wr(11, 8'h80); wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h11);
      wr(11, 8'h00);
      tick_wait();
      rd(4, rv); chk("R9 11AM to 12PM", rv, 8'h92);
      wr(11, 8'h80); wr(0, 8'h09); wr(11, 8'h00);
      tick_wait();
      rd(0, rv); chk("R8 BCD digit carry", rv, 8'h10);

      // R10 - R13: alarm, masking and clear-on-read
      set_time(10, 20, 29, 1, 1, 1, 0);
      wr(1, 8'd30); wr(3, 8'd20); wr(5, 8'd10);
      rd(1, rv); chk("R2 sec alarm", rv, 8'd30);
      rd(3, rv); chk("R2 min alarm", rv, 8'd20);
      rd(5, rv); chk("R2 hour alarm", rv, 8'd10);
      wr(11, 8'h26);
      rd(12, rv);
      tick_wait();
      chk("R11 irq on match", 8'(irq), 8'h01);
      rd(12, rv); chk("R11 alarm status", rv, 8'hB0);
      chk("R13 irq after read", 8'(irq), 8'h00);
      rd(12, rv); chk("R13 status cleared", rv, 8'h00);
      tick_wait();
      chk("R12 update masked", 8'(irq), 8'h00);
      rd(12, rv); chk("R10 update flag only", rv, 8'h10);
      wr(11, 8'h16);
      tick_wait();
      chk("R12 update irq", 8'(irq), 8'h01);
      rd(12, rv); chk("R12 status bit 7", rv, 8'h90);
      wr(11, 8'h46);
      tick_wait();
      chk("R12 periodic mask no irq", 8'(irq), 8'h00);
      rd(12, rv); chk("R12 periodic flag zero", rv, 8'h10);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
   end

endmodule